// File: doc/BRIEF.md
# Banked Processor Status Register File

This block keeps the status word that a processor core consults on every cycle: condition flags, interrupt masks, instruction-set selection and the operating mode. One current status register is shared by all modes. Each privileged exception mode also has its own saved status register, which holds the status in force when that mode was entered. The core reads and writes the current register, or the saved register that belongs to the current mode, through a single access port. A flags-only qualifier on a write limits the update to the four condition flags.

An exception-entry port takes a target mode. In one cycle it copies the current status into the target's saved register, switches the mode field to the target and masks interrupts. The block also drives the decoded IRQ and FIQ masks and the two-bit instruction-set state straight from the current register. Software sees a saved register only through the current mode. User and system modes have no saved register, and any saved-register access in those modes raises an error flag.

Top module: `status_bank`

## Requirements
- R1: After reset the current status is 0x000000D3 (supervisor mode 10011, I bit 7 and F bit 6 set). All five saved registers are zero.
- R2: With `rd_saved` low, `rd_data` shows the current status in the same cycle.
- R3: Outside user mode, a full write with `wr_saved` low and `wr_flags_only` low loads `wr_data` into the current status on the next clock edge.
- R4: A write with `wr_flags_only` high changes only bits 31:28 of the current status. Bits 27:0 keep their value.
- R5: In user mode (10000), every write to the current status changes only bits 31:28, whatever `wr_flags_only` is.
- R6: Saved-register reads and writes always reach the bank of the current mode. Five banks exist: FIQ 10001, IRQ 10010, supervisor 10011, abort 10111 and undefined 11011. Writes leave the other banks unchanged.
- R7: In a mode with no bank (user 10000, system 11111, or any other code), a saved-register read or write raises `acc_err` in the same cycle. The read returns zero and the write changes nothing.
- R8: Exception entry to a banked target copies the old current status into the target's bank. It sets mode bits 4:0 to the target and sets I (bit 7). F (bit 6) is set only when the target is FIQ. All other bits are kept.
- R9: When exception entry and a write fall in the same cycle, the entry wins and the write is dropped.
- R10: Exception entry to a target that has no bank is ignored, and any write in that cycle proceeds as normal.
- R11: `irq_masked` equals bit 7 and `fiq_masked` equals bit 6. `iset` is {J bit 24, T bit 5}, where 00 is standard, 01 is compact, 10 is bytecode and 11 is reserved.
- R12: A flags-only write to a saved register changes only bits 31:28 of that bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_saved | input | 1 | Read port selects the saved register of the current mode |
| rd_data | output | 32 | Read data (combinational) |
| wr_en | input | 1 | Write request |
| wr_saved | input | 1 | Write targets the saved register of the current mode |
| wr_flags_only | input | 1 | Restrict the write to bits 31:28 |
| wr_data | input | 32 | Write data |
| exc_en | input | 1 | Exception entry request |
| exc_mode | input | 5 | Target mode of exception entry |
| cur_psr | output | 32 | Current status register |
| acc_err | output | 1 | Saved-register access attempted in a mode with no bank |
| irq_masked | output | 1 | IRQ disabled |
| fiq_masked | output | 1 | FIQ disabled |
| iset | output | 2 | Instruction-set state {J,T} |

## Verification
Directed steps come first. They walk the block through privileged full writes, flags-only writes, a user-mode write that tries to change the control bits, and entries into IRQ and FIQ. These steps show that the write mask depends on both privilege and the qualifier, and that F is forced only on FIQ entry. Random steps then choose write data whose mode field is drawn from every legal encoding plus an illegal one, and mix in simultaneous entry and write. This separates bank selection by the current mode from selection by the written value, and shows entry priority and ignored entries. Every saved-register read made after a mode change shows whether a write or an entry reached the wrong bank.

// File: rtl/status_bank_pkg.sv
package status_bank_pkg;
  localparam int PSR_W   = 32;
  localparam int MODE_W  = 5;
  localparam int NBANK   = 5;
  localparam int BIDX_W  = $clog2(NBANK);
  localparam int FLAG_LO = 28;
  localparam int POS_I   = 7;
  localparam int POS_F   = 6;
  localparam int POS_T   = 5;
  localparam int POS_J   = 24;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  localparam logic [PSR_W-1:0] RESET_PSR = 32'h0000_00D3;

  typedef struct packed {
    logic              hit;
    logic [BIDX_W-1:0] idx;
  } bank_sel_t;

  function automatic bank_sel_t bank_lookup(input logic [MODE_W-1:0] m);
    bank_sel_t s;
    s = '0;
    unique case (m)
      MODE_FIQ: s = '{hit: 1'b1, idx: BIDX_W'(0)};
      MODE_IRQ: s = '{hit: 1'b1, idx: BIDX_W'(1)};
      MODE_SVC: s = '{hit: 1'b1, idx: BIDX_W'(2)};
      MODE_ABT: s = '{hit: 1'b1, idx: BIDX_W'(3)};
      MODE_UND: s = '{hit: 1'b1, idx: BIDX_W'(4)};
      default:  s = '0;
    endcase
    return s;
  endfunction

  function automatic logic [PSR_W-1:0] merge_flags(input logic [PSR_W-1:0] old_v,
                                                   input logic [PSR_W-1:0] new_v);
    return {new_v[PSR_W-1:FLAG_LO], old_v[FLAG_LO-1:0]};
  endfunction

  function automatic logic [PSR_W-1:0] entry_value(input logic [PSR_W-1:0] old_v,
                                                   input logic [MODE_W-1:0] tgt);
    logic [PSR_W-1:0] v;
    v = old_v;
    v[MODE_W-1:0] = tgt;
    v[POS_I] = 1'b1;
    if (tgt == MODE_FIQ) v[POS_F] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/sb_mode_decode.sv
module sb_mode_decode
  import status_bank_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output logic              hit,
  output logic [BIDX_W-1:0] idx
);
  bank_sel_t sel;
  always_comb begin
    sel = bank_lookup(mode);
    hit = sel.hit;
    idx = sel.idx;
  end
endmodule

// File: rtl/sb_bank_array.sv
module sb_bank_array #(
  parameter int DW = 32,
  parameter int NB = 5,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] bank_q [NB];

  for (genvar g = 0; g < NB; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            bank_q[g] <= '0;
      else if (we && widx == IW'(g))         bank_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NB; i++)
      if (ridx == IW'(i)) rdata = bank_q[i];
  end
endmodule

// File: rtl/status_bank.sv
module status_bank
  import status_bank_pkg::*;
#(
  parameter int DW = PSR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_saved,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic          wr_saved,
  input  logic          wr_flags_only,
  input  logic [DW-1:0] wr_data,
  input  logic          exc_en,
  input  logic [4:0]    exc_mode,
  output logic [DW-1:0] cur_psr,
  output logic          acc_err,
  output logic          irq_masked,
  output logic          fiq_masked,
  output logic [1:0]    iset
);
  logic [DW-1:0]     cur_q, cur_d;
  logic              cur_hit, tgt_hit;
  logic [BIDX_W-1:0] cur_idx, tgt_idx;
  logic [DW-1:0]     bank_rd, bank_wdata;
  logic [BIDX_W-1:0] bank_widx;
  logic              bank_we;

  // named internal events
  logic exc_go, in_user, cur_wr_go, sav_wr_go, saved_touch;

  sb_mode_decode u_cur_dec (.mode(cur_q[MODE_W-1:0]), .hit(cur_hit), .idx(cur_idx));
  sb_mode_decode u_tgt_dec (.mode(exc_mode),          .hit(tgt_hit), .idx(tgt_idx));

  sb_bank_array #(.DW(DW), .NB(NBANK)) u_banks (
    .clk(clk), .rst_n(rst_n),
    .we(bank_we), .widx(bank_widx), .wdata(bank_wdata),
    .ridx(cur_idx), .rdata(bank_rd)
  );

  assign exc_go      = exc_en & tgt_hit;
  assign in_user     = (cur_q[MODE_W-1:0] == MODE_USR);
  assign cur_wr_go   = wr_en & ~wr_saved & ~exc_go;
  assign sav_wr_go   = wr_en & wr_saved & cur_hit & ~exc_go;
  assign saved_touch = rd_saved | (wr_en & wr_saved);

  always_comb begin
    cur_d = cur_q;
    if (exc_go)
      cur_d = entry_value(cur_q, exc_mode);
    else if (cur_wr_go)
      cur_d = (wr_flags_only | in_user) ? merge_flags(cur_q, wr_data) : wr_data;
  end

  always_comb begin
    bank_we    = exc_go | sav_wr_go;
    bank_widx  = exc_go ? tgt_idx : cur_idx;
    if (exc_go)             bank_wdata = cur_q;
    else if (wr_flags_only) bank_wdata = merge_flags(bank_rd, wr_data);
    else                    bank_wdata = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= RESET_PSR;
    else        cur_q <= cur_d;
  end

  assign rd_data    = rd_saved ? (cur_hit ? bank_rd : '0) : cur_q;
  assign acc_err    = saved_touch & ~cur_hit;
  assign cur_psr    = cur_q;
  assign irq_masked = cur_q[POS_I];
  assign fiq_masked = cur_q[POS_F];
  assign iset       = {cur_q[POS_J], cur_q[POS_T]};
endmodule

// File: rtl/status_bank_checker.sv
module status_bank_checker
  import status_bank_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        rd_saved,
  input logic [31:0] rd_data,
  input logic        wr_en,
  input logic        wr_saved,
  input logic        wr_flags_only,
  input logic [31:0] wr_data,
  input logic        exc_en,
  input logic [4:0]  exc_mode,
  input logic [31:0] cur_psr,
  input logic        acc_err
);
  logic tgt_ok;
  assign tgt_ok = bank_lookup(exc_mode).hit;

  p_full_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_saved && !wr_flags_only && !(exc_en && tgt_ok) && cur_psr[4:0] != MODE_USR)
    |=> cur_psr == $past(wr_data));

  p_flags_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_saved && wr_flags_only && !(exc_en && tgt_ok))
    |=> cur_psr[27:0] == $past(cur_psr[27:0]) && cur_psr[31:28] == $past(wr_data[31:28]));

  p_user_protect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_saved && !(exc_en && tgt_ok) && cur_psr[4:0] == MODE_USR)
    |=> $stable(cur_psr[27:0]));

  p_no_bank_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_saved && acc_err) |-> rd_data == '0);

  p_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_en && tgt_ok)
    |=> cur_psr[4:0] == $past(exc_mode) && cur_psr[7] && cur_psr[31:8] == $past(cur_psr[31:8]));

  p_bad_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_en && !tgt_ok && !wr_en) |=> $stable(cur_psr));
endmodule

bind status_bank status_bank_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rd_saved(rd_saved), .rd_data(rd_data),
  .wr_en(wr_en), .wr_saved(wr_saved), .wr_flags_only(wr_flags_only),
  .wr_data(wr_data), .exc_en(exc_en), .exc_mode(exc_mode),
  .cur_psr(cur_psr), .acc_err(acc_err)
);

// File: tb/status_bank_test.sv
`timescale 1ns/1ps
module status_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_saved = 1'b0, wr_en = 1'b0, wr_saved = 1'b0, wr_flags_only = 1'b0;
  logic [31:0] wr_data = '0;
  logic        exc_en = 1'b0;
  logic [4:0]  exc_mode = '0;
  logic [31:0] rd_data, cur_psr;
  logic        acc_err, irq_masked, fiq_masked;
  logic [1:0]  iset;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_cur;
  logic [31:0] m_bank [5];

  always #10 clk = ~clk;

  status_bank uut (
    .clk(clk), .rst_n(rst_n), .rd_saved(rd_saved), .rd_data(rd_data),
    .wr_en(wr_en), .wr_saved(wr_saved), .wr_flags_only(wr_flags_only),
    .wr_data(wr_data), .exc_en(exc_en), .exc_mode(exc_mode),
    .cur_psr(cur_psr), .acc_err(acc_err), .irq_masked(irq_masked),
    .fiq_masked(fiq_masked), .iset(iset)
  );

  // Bank slot of a mode per R6; -1 when the mode has no bank (R7).
  function automatic int slot(input logic [4:0] m);
    if (m == 5'h11) return 0;
    if (m == 5'h12) return 1;
    if (m == 5'h13) return 2;
    if (m == 5'h17) return 3;
    if (m == 5'h1B) return 4;
    return -1;
  endfunction

  function automatic logic [4:0] pick_mode(input int k);
    case (k % 8)
      0: return 5'h10; 1: return 5'h11; 2: return 5'h12; 3: return 5'h13;
      4: return 5'h17; 5: return 5'h1B; 6: return 5'h1F; default: return 5'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic check_state(input string tag);
    check(tag, cur_psr, m_cur);
    check("R11 irq", {31'b0, irq_masked}, {31'b0, m_cur[7]});
    check("R11 fiq", {31'b0, fiq_masked}, {31'b0, m_cur[6]});
    check("R11 iset", {30'b0, iset}, {30'b0, m_cur[24], m_cur[5]});
  endtask

  // One access cycle, inputs driven right after a falling edge.
  task automatic step(input bit rs, input bit we, input bit ws, input bit wf,
                      input logic [31:0] wd, input bit ee, input logic [4:0] em);
    int cs, ts;
    string tag;
    logic [31:0] fmask;
    fmask = 32'hF000_0000;
    rd_saved = rs; wr_en = we; wr_saved = ws; wr_flags_only = wf;
    wr_data = wd; exc_en = ee; exc_mode = em;
    cs = slot(m_cur[4:0]);
    ts = slot(em);
    #1;
    if (!rs) check("R2 read current", rd_data, m_cur);
    else if (cs < 0) check("R7 read no-bank", rd_data, 32'h0);
    else check("R6 read saved", rd_data, m_bank[cs]);
    check("R7 acc_err", {31'b0, acc_err}, {31'b0, (rs | (we & ws)) && cs < 0});
    // expected next state
    if (ee && ts >= 0) begin
      tag = we ? "R9 entry beats write" : "R8 entry";
      m_bank[ts] = m_cur;
      m_cur[4:0] = em;
      m_cur[7] = 1'b1;
      if (em == 5'h11) m_cur[6] = 1'b1;
    end else begin
      tag = ee ? "R10 ignored entry" : "R2 idle";
      if (we && !ws) begin
        if (wf) tag = "R4 flags write";
        else if (m_cur[4:0] == 5'h10) tag = "R5 user write";
        else tag = "R3 full write";
        if (wf || m_cur[4:0] == 5'h10) m_cur = (m_cur & ~fmask) | (wd & fmask);
        else m_cur = wd;
      end else if (we && ws) begin
        tag = wf ? "R12 saved flags write" : "R6 saved write";
        if (cs >= 0) begin
          if (wf) m_bank[cs] = (m_bank[cs] & ~fmask) | (wd & fmask);
          else m_bank[cs] = wd;
        end
      end
    end
    @(negedge clk);
    check_state(tag);
  endtask

  task automatic read_all_banks();
    // visit each banked mode via full write (privileged) and read its bank
    for (int k = 1; k <= 5; k++) begin
      if (m_cur[4:0] == 5'h10) step(0, 0, 0, 0, '0, 1, 5'h13);
      step(0, 1, 0, 0, {m_cur[31:5], pick_mode(k)}, 0, 5'h00);
      step(1, 0, 0, 0, '0, 0, 5'h00);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 5; i++) m_bank[i] = '0;
    m_cur = 32'h0000_00D3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_state("R1 reset current");
    read_all_banks();
    for (int i = 0; i < 5; i++) check("R1 reset bank", m_bank[i], 32'h0);
    // directed
    step(0, 1, 0, 0, 32'h5100_0033, 0, 5'h00);          // R3 full write, T set, SVC
    step(0, 1, 0, 1, 32'hA0FF_FF10, 0, 5'h00);          // R4 flags only
    step(0, 0, 0, 0, '0, 1, 5'h12);                     // R8 IRQ entry
    step(1, 0, 0, 0, '0, 0, 5'h00);                     // R6 read IRQ bank
    step(0, 0, 0, 0, '0, 1, 5'h11);                     // R8 FIQ entry sets F
    step(0, 1, 1, 1, 32'hF123_4567, 0, 5'h00);          // R12 saved flags only
    step(1, 0, 0, 0, '0, 0, 5'h00);
    step(0, 1, 0, 0, 32'h3000_0010, 1, 5'h17);          // R9 entry wins
    step(0, 1, 0, 0, 32'h0100_0010, 1, 5'h00);          // R10 ignored, write to user
    step(0, 1, 0, 0, 32'h9000_00D3, 0, 5'h00);          // R5 user cannot leave
    step(1, 1, 1, 0, 32'hDEAD_BEEF, 0, 5'h00);          // R7 saved access in user
    step(0, 0, 0, 0, '0, 1, 5'h1B);
    step(0, 1, 0, 0, 32'h0000_001F, 0, 5'h00);          // system mode
    step(1, 1, 1, 0, 32'h1234_5678, 0, 5'h00);          // R7 in system
    read_all_banks();
    // random
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] d;
      d = $urandom();
      d[4:0] = pick_mode($urandom());
      step($urandom() % 2, ($urandom() % 3) != 0, $urandom() % 2, ($urandom() % 4) == 0,
           d, ($urandom() % 6) == 0, pick_mode($urandom()));
      if (m_cur[4:0] == 5'h10 && ($urandom() % 4) == 0)
        step(0, 0, 0, 0, '0, 1, pick_mode(1 + $urandom() % 5));
    end
    read_all_banks();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule